// File: doc/BRIEF.md
# Gated Timer/Counter Channel

One channel of a classic microcontroller-style timer/counter. A 16-bit count, kept as a low byte and a high byte, advances on one of two sources. The first is a prescaled internal tick. The second is falling edges of an external count pin. A run bit enables counting. A gate bit can make counting also depend on an external gate pin. Three counting modes are supported: a 13-bit counter, a 16-bit counter, and an 8-bit counter that reloads itself from the high byte. On overflow the block raises a sticky flag and a one-cycle pulse. The pulse goes to an interrupt controller, which can clear the flag with an acknowledge.

Software reaches four byte-wide registers through a simple write port and a combinational read port:
- address 0: count low byte
- address 1: count high byte
- address 2: mode nibble
- address 3: control

A small state machine qualifies counting. It is registered, so a change of run bit, mode or gate level takes effect one clock later. It has four states:
- `ST_HALT`: run clear.
- `ST_PARKED`: run set but mode 11 selected.
- `ST_GATE_WAIT`: run set, gate bit set, synchronized gate pin low.
- `ST_ACTIVE`: all other cases.

Each clock the next state is chosen by these rules, first match wins:
1. Run clear goes to `ST_HALT`.
2. Mode 11 goes to `ST_PARKED`.
3. Gate bit set with the gate pin low goes to `ST_GATE_WAIT`.
4. Otherwise the next state is `ST_ACTIVE`.

These transitions apply from every state.

Top module: `gtc_channel`

## Requirements
- R1: After reset the count bytes, mode nibble, run bit and overflow flag are all zero, the state is `ST_HALT` and no overflow pulse is driven.
- R2: With the run bit (control bit 0) clear, the count holds its value; clearing run stops counting one clock after the write and leaves the count unchanged.
- R3: With the gate bit (mode bit 3) set, counting happens only while the synchronized gate pin is high (state `ST_GATE_WAIT` otherwise).
- R4: With the gate bit clear, the gate pin level has no effect on counting.
- R5: With the source select (mode bit 2) clear, the count advances by one on each clock in which `tick_i` is high while the state is `ST_ACTIVE`.
- R6: With the source select set, the count pin passes through a two-flop synchronizer. Each high-to-low transition of the synchronized value gives exactly one count, and `tick_i` is ignored.
- R7: Mode 00 (mode bits 1:0) counts the 13-bit value {high byte, low byte bits 4:0}. It wraps from 0x1FFF to 0 with overflow, and low byte bits 7:5 are left untouched.
- R8: Mode 01 counts the full 16-bit value {high, low} and overflows when wrapping from 0xFFFF to 0.
- R9: Mode 10 counts the low byte only. Past 0xFF it loads the high byte into the low byte and overflows; the high byte is not changed by counting.
- R10: Overflow sets the flag (read as control bit 1) and drives `ovf_pulse` high for exactly that one clock. The flag stays set until `irq_ack` or a control write with bit 1 set clears it. A new overflow in the same clock wins over a clear.
- R11: A write to either count byte wins over an increment in the same clock. That clock neither counts nor overflows.
- R12: Mode 11 is not a counting mode: with it selected, the count never changes except by writes.
- R13: The mode nibble is read back at address 2 as {gate, source select, mode bit 1, mode bit 0} in bits 3:0. The control register is read at address 3 as {flag, run} in bits 1:0, and the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled internal count tick, one clock wide per tick |
| cnt_pin | input | 1 | External count pin, asynchronous |
| gate_pin | input | 1 | External gate pin, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-clock pulse on each overflow |

## Verification
The bench aims at the wrap boundaries of every mode:
- A 13-bit counter that carried into low byte bits 5 to 7 would corrupt them.
- An 8-bit reload that used the new high byte, or counted the high byte, would show a wrong low byte after the wrap.

It drives count-pin edges of varied spacing while `tick_i` stays high. An edge detector that counted levels, or counted rising edges, then overcounts or shifts by a cycle. It also times writes to coincide with increments and overflows, and an acknowledge to coincide with a new overflow. A wrong priority there shows up as a stray count or a lost flag. A reference model compares every register, the flag and the pulse on every clock. A one-cycle error in the latency of the state machine or the synchronizer is therefore reported.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    typedef enum logic [1:0] {
        ST_HALT      = 2'd0,
        ST_GATE_WAIT = 2'd1,
        ST_ACTIVE    = 2'd2,
        ST_PARKED    = 2'd3
    } gtc_state_e;

    typedef enum logic [1:0] {
        MD_13  = 2'b00,
        MD_16  = 2'b01,
        MD_8R  = 2'b10,
        MD_OFF = 2'b11
    } gtc_mode_e;

    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    // Mode nibble bit positions
    localparam int MB_GATE = 3;
    localparam int MB_SRC  = 2;

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dsync,
    output logic [WIDTH-1:0] dfall
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-1:0], din[b]};
            end
        end

        assign dsync[b] = chain_q[LAST];
        assign dfall[b] = chain_q[STAGES] & ~chain_q[LAST];
    end

endmodule

// File: rtl/gtc_count.sv
module gtc_count
    import gtc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  gtc_mode_e         mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf
);
    localparam int W13 = BYTE_W + PRE_W;
    localparam int W16 = 2 * BYTE_W;
    localparam logic [W13:0]    ONE13 = 1;
    localparam logic [W16:0]    ONE16 = 1;
    localparam logic [BYTE_W:0] ONE8  = 1;

    logic              inc_eff;
    logic [BYTE_W-1:0] lo_d, hi_d;
    logic [W13:0]      sum13;
    logic [W16:0]      sum16;
    logic [BYTE_W:0]   sum8;

    // Register writes pre-empt the increment
    assign inc_eff = inc & ~(wr_lo | wr_hi);
    assign sum13   = {1'b0, hi_q, lo_q[PRE_W-1:0]} + ONE13;
    assign sum16   = {1'b0, hi_q, lo_q} + ONE16;
    assign sum8    = {1'b0, lo_q} + ONE8;

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        ovf  = 1'b0;
        if (inc_eff) begin
            unique case (mode)
                MD_13: begin
                    lo_d[PRE_W-1:0] = sum13[PRE_W-1:0];
                    hi_d            = sum13[W13-1:PRE_W];
                    ovf             = sum13[W13];
                end
                MD_16: begin
                    lo_d = sum16[BYTE_W-1:0];
                    hi_d = sum16[W16-1:BYTE_W];
                    ovf  = sum16[W16];
                end
                MD_8R: begin
                    lo_d = sum8[BYTE_W] ? hi_q : sum8[BYTE_W-1:0];
                    ovf  = sum8[BYTE_W];
                end
                MD_OFF: begin
                    ovf = 1'b0;
                end
            endcase
        end
        if (wr_lo) lo_d = wr_data;
        if (wr_hi) hi_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    // R9
    reload_from_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && mode == MD_8R && (&lo_q) && !wr_lo && !wr_hi) |=> (lo_q == $past(hi_q)));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |-> !ovf);

    // R12
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R7
    upper_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_13 && !wr_lo) |=> (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));

endmodule

// File: rtl/gtc_channel.sv
module gtc_channel
    import gtc_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PRE_W     = 5,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cnt_pin,
    input  logic              gate_pin,
    input  logic              irq_ack,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              ovf_pulse
);
    localparam int PIN_N = 2;

    gtc_state_e        state_q, state_d;
    logic [3:0]        mode_q;
    logic              run_q;
    logic              flag_q, pulse_q;
    logic [PIN_N-1:0]  pin_sync, pin_fall;
    logic              gate_s, cnt_fall;
    logic              count_en, event_hit, ovf;
    logic              wr_lo, wr_hi, wr_mode, wr_ctrl;
    logic [BYTE_W-1:0] lo_q, hi_q;

    gtc_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({gate_pin, cnt_pin}),
        .dsync (pin_sync),
        .dfall (pin_fall)
    );

    assign gate_s   = pin_sync[1];
    assign cnt_fall = pin_fall[0];

    assign wr_lo   = wr_en && (wr_addr == A_LO);
    assign wr_hi   = wr_en && (wr_addr == A_HI);
    assign wr_mode = wr_en && (wr_addr == A_MODE);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    // Next-state selection
    always_comb begin
        if (!run_q)
            state_d = ST_HALT;
        else if (mode_q[1:0] == MD_OFF)
            state_d = ST_PARKED;
        else if (mode_q[MB_GATE] && !gate_s)
            state_d = ST_GATE_WAIT;
        else
            state_d = ST_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // State outputs
    always_comb begin
        unique case (state_q)
            ST_HALT:      count_en = 1'b0;
            ST_GATE_WAIT: count_en = 1'b0;
            ST_ACTIVE:    count_en = 1'b1;
            ST_PARKED:    count_en = 1'b0;
        endcase
    end

    assign event_hit = mode_q[MB_SRC] ? cnt_fall : tick_i;

    gtc_count #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (count_en & event_hit),
        .mode    (gtc_mode_e'(mode_q[1:0])),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .ovf     (ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            run_q   <= 1'b0;
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= ovf;
            if (wr_mode) mode_q <= wr_data[3:0];
            if (wr_ctrl) run_q  <= wr_data[0];
            if (ovf)
                flag_q <= 1'b1;
            else if (irq_ack || (wr_ctrl && wr_data[1]))
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_LO:   rd_data = lo_q;
            A_HI:   rd_data = hi_q;
            A_MODE: rd_data = BYTE_W'(mode_q);
            A_CTRL: rd_data = BYTE_W'({flag_q, run_q});
        endcase
    end

    assign ovf_flag  = flag_q;
    assign ovf_pulse = pulse_q;

    // R10
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && mode_q[1:0] != MD_8R) |=> !ovf_pulse || $past(wr_lo || wr_hi) == 1'b0);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R3
    gate_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE_WAIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_HALT && !ovf_flag && !ovf_pulse));

endmodule

// File: tb/gtc_channel_tb.sv
module gtc_channel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       gate_pin = 1'b0;
    logic       irq_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_flag, ovf_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    gtc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
    );

    // Behavioural reference
    int   m_lo, m_hi, m_mode, m_st;
    bit   m_run, m_flag, m_pulse;
    bit   c_a, c_b, c_old, g_a, g_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_mode = 0; m_st = 0;
            m_run = 0; m_flag = 0; m_pulse = 0;
            c_a = 0; c_b = 0; c_old = 0; g_a = 0; g_b = 0;
        end else begin
            bit ev, wrc, ovf;
            int v, nst;
            ev  = ((m_mode >> 2) & 1) ? (c_old && !c_b) : tick_i;
            wrc = wr_en && (wr_addr < 2);
            ovf = 0;
            if (m_st == 2 && ev && !wrc) begin
                case (m_mode & 3)
                    0: begin
                        v = m_hi * 32 + (m_lo % 32);
                        if (v == 8191) begin v = 0; ovf = 1; end else v++;
                        m_hi = v / 32;
                        m_lo = (m_lo / 32) * 32 + (v % 32);
                    end
                    1: begin
                        v = m_hi * 256 + m_lo;
                        if (v == 65535) begin v = 0; ovf = 1; end else v++;
                        m_hi = v / 256; m_lo = v % 256;
                    end
                    2: begin
                        if (m_lo == 255) begin m_lo = m_hi; ovf = 1; end else m_lo++;
                    end
                    default: ;
                endcase
            end
            if (!m_run) nst = 0;
            else if ((m_mode & 3) == 3) nst = 3;
            else if (((m_mode >> 3) & 1) && !g_b) nst = 1;
            else nst = 2;
            m_pulse = ovf;
            if (ovf) m_flag = 1;
            else if (irq_ack || (wr_en && wr_addr == 3 && wr_data[1])) m_flag = 0;
            if (wr_en) begin
                case (wr_addr)
                    0: m_lo = wr_data;
                    1: m_hi = wr_data;
                    2: m_mode = wr_data & 15;
                    3: m_run = wr_data[0];
                endcase
            end
            m_st = nst;
            c_old = c_b; c_b = c_a; c_a = cnt_pin;
            g_b = g_a; g_a = gate_pin;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return m_mode;
            default: return m_flag * 2 + m_run;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(cur_req, $sformatf("rd[%0d]", rd_addr), rd_data, exp_rd(rd_addr));
            check(cur_req, "ovf_flag", ovf_flag, m_flag);
            check(cur_req, "ovf_pulse", ovf_pulse, m_pulse);
            rd_addr <= rd_addr + 2'd1;
        end
        if (cyc > 60000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_edge(input int lo_c, input int hi_c);
        @(negedge clk); cnt_pin = 1'b0;
        idle(lo_c);
        cnt_pin = 1'b1;
        idle(hi_c);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1
        @(negedge clk);
        cur_req = "R1";
        check("R1", "flag after reset", ovf_flag, 0);
        check("R1", "pulse after reset", ovf_pulse, 0);
        idle(4);

        // R13 register readback layout
        cur_req = "R13";
        wr(2'd2, 8'hFB);
        idle(4);
        wr(2'd2, 8'h01);

        // R5 / R8 timer from tick, 16-bit wrap
        cur_req = "R8";
        wr(2'd0, 8'hFA); wr(2'd1, 8'hFF);
        tick_i = 1'b1;
        wr(2'd3, 8'h01);
        idle(12);
        // R10 clear by software
        cur_req = "R10";
        wr(2'd3, 8'h03);
        idle(3);
        // R5 sparse tick
        cur_req = "R5";
        for (int i = 0; i < 20; i++) begin
            tick_i = (i % 3 == 0); @(negedge clk);
        end
        tick_i = 1'b1;

        // R2 halt
        cur_req = "R2";
        wr(2'd3, 8'h00);
        idle(6);

        // R3 gate set
        cur_req = "R3";
        wr(2'd2, 8'h09);
        gate_pin = 1'b0;
        wr(2'd3, 8'h01);
        idle(5);
        gate_pin = 1'b1; idle(6);
        gate_pin = 1'b0; idle(5);

        // R4 gate clear, pin ignored
        cur_req = "R4";
        wr(2'd2, 8'h01);
        idle(6);

        // R6 external falling edges, tick held high
        cur_req = "R6";
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        for (int i = 1; i < 6; i++) pin_edge(i, 6 - i);
        pin_edge(1, 1);
        pin_edge(3, 2);
        idle(4);

        // R7 13-bit wrap, upper low bits kept
        cur_req = "R7";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFC); wr(2'd1, 8'hFF);
        idle(10);

        // R9 auto reload
        cur_req = "R9";
        wr(2'd2, 8'h02);
        wr(2'd1, 8'hF0); wr(2'd0, 8'hFC);
        idle(40);
        // R10 ack clears, and overflow with ack keeps flag set
        cur_req = "R10";
        @(negedge clk); irq_ack = 1'b1;
        idle(25);
        irq_ack = 1'b0;
        idle(3);

        // R11 writes collide with increments and overflow
        cur_req = "R11";
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        idle(4);
        wr(2'd0, 8'h10);

        // R12 mode 11 parks
        cur_req = "R12";
        wr(2'd2, 8'h03);
        idle(10);
        wr(2'd3, 8'h02);
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule